// File: doc/BRIEF.md
# UART Modem Line Control and Status Unit

This unit holds the modem control and modem status registers of a 16550-style UART. It sits on a byte-wide register bus with an address, a write strobe, a read strobe and combinational read data. It drives the request-to-send and data-terminal-ready lines. It samples the clear-to-send, data-set-ready, ring and carrier-detect inputs. The status register keeps the live input levels in its upper nibble and sticky change flags in its lower nibble. The unit raises a modem-status interrupt flag while that source is enabled and any change flag is set.

The inputs are not watched continuously. They are sampled in four cases: when the status register is read, when the modem-status interrupt enable is written as one, on a periodic poll while that enable stays set, and once, one character time after a control-line change. The character time comes from the divisor latch and from the frame fields of the line control register. The serial shifters and the FIFOs belong to other blocks.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the status register reads 0xB0 (carrier, data-set-ready and clear-to-send set). The control register reads 0x08, the divisor latch reads 12, and the interrupt-enable and line-control registers read 0. `rts_o`, `dtr_o` and `ms_irq_o` are 0.
- R2: Each input passes through a two-flop synchronizer. On every sample, status bits 7..4 take the synchronized levels of carrier, ring, data-set-ready and clear-to-send, in that order from bit 7 down.
- R3: A sample sets status bit 0 if clear-to-send changed, bit 1 if data-set-ready changed, and bit 3 if carrier changed. These flags stay set until the status register is read.
- R4: Status bit 2 is set only by a sample in which ring goes from 1 to 0. A rise of ring leaves it unchanged.
- R5: A read of the status register (address 6) outside loopback samples the inputs and returns the sampled value. It then clears bits 3..0.
- R6: A write to address 1 while line-control bit 7 is 0 stores the low four data bits as the interrupt-enable register. Writing bit 3 as one samples at once and then every CLK_HZ/POLL_HZ cycles. Writing it as zero stops periodic sampling and cancels any pending sample.
- R7: A write to the control register (address 4) keeps bits 4..0. A write that has bit 4 clear and changes the register drives `rts_o` from bit 1 and `dtr_o` from bit 0. A write with bit 4 set (loopback) leaves both lines unchanged.
- R8: A control-line change under R7 arms a one-shot sample. The sample happens exactly one character time, in clock cycles, after the edge that accepted the write.
- R9: The character time is divisor × (CLK_HZ/BASE_BAUD) × frame. The frame is (LCR[1:0]+5) + (LCR[2] ? 2 : 1) + LCR[3]. The divisor latch sits at address 0 (low byte) and address 1 (high byte) while LCR[7] is 1.
- R10: While the divisor latch holds zero, the character time keeps its last value.
- R11: In loopback, a status read returns control bit 1 in bit 4 and control bit 0 in bit 5, with all other bits 0. The read neither samples nor clears.
- R12: `ms_irq_o` is 1 exactly when interrupt-enable bit 3 is set and any of status bits 3..0 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; side effects happen at the edge that ends the strobe cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| cts_i | input | 1 | Clear-to-send level, asynchronous |
| dsr_i | input | 1 | Data-set-ready level, asynchronous |
| ri_i | input | 1 | Ring indicator level, asynchronous |
| dcd_i | input | 1 | Carrier detect level, asynchronous |
| rts_o | output | 1 | Request-to-send line |
| dtr_o | output | 1 | Data-terminal-ready line |
| ms_irq_o | output | 1 | Modem-status interrupt flag |

## Verification
The assertions assume that `bus_wr` and `bus_rd` are never high in the same cycle, because the timer priority rests on there being one bus operation per cycle. The stimulus issues one strobe per task and keeps each strobe high for a single cycle. It changes the modem inputs only on falling edges. Before any sample whose outcome it measures, it holds them for at least three cycles, so the synchronized value is settled. Poll and character-time measurements are started right after a status read or a control write, so no other pending sample can fall inside the window.

// File: rtl/uart_modem_pkg.sv
package uart_modem_pkg;

    localparam int TIME_W = 32;
    localparam logic [15:0] RST_DIV = 16'd12;

    localparam logic [2:0] A_DLL  = 3'd0;
    localparam logic [2:0] A_IER  = 3'd1;
    localparam logic [2:0] A_LCR  = 3'd3;
    localparam logic [2:0] A_MCR  = 3'd4;
    localparam logic [2:0] A_MSR  = 3'd6;

    // modem lines, packed MSB first: carrier, ring, set-ready, clear-to-send
    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } ms_lines_t;

    typedef struct packed {
        ms_lines_t lvl;
        ms_lines_t dlt;
    } msr_t;

    typedef struct packed {
        logic [2:0] rsv;
        logic       loop;
        logic       out2;
        logic       out1;
        logic       rts;
        logic       dtr;
    } mcr_t;

    localparam msr_t MSR_RST = 8'hB0;
    localparam mcr_t MCR_RST = 8'h08;

    // fold a fresh sample into the status value
    function automatic msr_t msr_merge(msr_t cur, ms_lines_t now);
        msr_t      r;
        ms_lines_t chg;
        chg    = cur.lvl ^ now;
        r.lvl  = now;
        r.dlt  = cur.dlt | chg;
        r.dlt.ri = cur.dlt.ri | (cur.lvl.ri & ~now.ri);
        return r;
    endfunction

    function automatic logic [3:0] frame_bits(logic [3:0] fmt);
        return 4'(fmt[1:0]) + 4'd5 + (fmt[2] ? 4'd2 : 4'd1) + 4'(fmt[3]);
    endfunction

endpackage

// File: rtl/umc_sync.sv
module umc_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic stab_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                stab_q <= 1'b0;
            end else begin
                meta_q <= d_i[g];
                stab_q <= meta_q;
            end
        end
        assign q_o[g] = stab_q;
    end
endmodule

// File: rtl/umc_chartime.sv
module umc_chartime
    import uart_modem_pkg::*;
#(
    parameter int CLK_HZ    = 58_982_400,
    parameter int BASE_BAUD = 115_200
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        fmt_i,
    input  logic [15:0]       div_i,
    output logic [TIME_W-1:0] char_o
);
    localparam int UNIT = CLK_HZ / BASE_BAUD;
    localparam logic [TIME_W-1:0] RST_CHAR = TIME_W'(int'(RST_DIV) * UNIT * 6);

    logic [TIME_W-1:0] prod;
    assign prod = TIME_W'(div_i) * TIME_W'(UNIT) * TIME_W'(frame_bits(fmt_i));

    always_ff @(posedge clk) begin
        if (rst) begin
            char_o <= RST_CHAR;
        end else if (div_i != 16'd0) begin
            char_o <= prod;
        end
    end
endmodule

// File: rtl/umc_timer.sv
module umc_timer
    import uart_modem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [TIME_W-1:0] val_i,
    input  logic              stop_i,
    output logic              fire_o,
    output logic              armed_o
);
    logic [TIME_W-1:0] cnt_q;
    logic              armed_q;

    assign fire_o  = armed_q && (cnt_q == TIME_W'(1));
    assign armed_o = armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (load_i) begin
            cnt_q   <= val_i;
            armed_q <= 1'b1;
        end else if (stop_i) begin
            armed_q <= 1'b0;
        end else if (armed_q) begin
            if (fire_o) armed_q <= 1'b0;
            else        cnt_q   <= cnt_q - TIME_W'(1);
        end
    end
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
    import uart_modem_pkg::*;
#(
    parameter int CLK_HZ    = 58_982_400,
    parameter int BASE_BAUD = 115_200,
    parameter int POLL_HZ   = 100
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       cts_i,
    input  logic       dsr_i,
    input  logic       ri_i,
    input  logic       dcd_i,
    output logic       rts_o,
    output logic       dtr_o,
    output logic       ms_irq_o
);
    localparam logic [TIME_W-1:0] POLL_CYC = TIME_W'(CLK_HZ / POLL_HZ);

    logic [7:0]        lcr_q;
    logic [3:0]        ier_q;
    logic [15:0]       div_q;
    mcr_t              mcr_q;
    msr_t              msr_q;
    logic              rts_q, dtr_q;

    ms_lines_t         sync_lvl;
    msr_t              msr_live;
    logic [TIME_W-1:0] char_cyc;
    logic              tmr_load, tmr_stop, tmr_fire, tmr_armed;
    logic [TIME_W-1:0] tmr_val;

    logic dlab, wr_dll, wr_dlm, wr_ier, wr_lcr, wr_mcr;
    logic rd_msr_live, mcr_kick, sample;
    mcr_t mcr_new;

    umc_sync #(.W(4)) sync_i (
        .clk (clk),
        .rst (rst),
        .d_i ({dcd_i, ri_i, dsr_i, cts_i}),
        .q_o (sync_lvl)
    );

    umc_chartime #(.CLK_HZ(CLK_HZ), .BASE_BAUD(BASE_BAUD)) ctime_i (
        .clk    (clk),
        .rst    (rst),
        .fmt_i  (lcr_q[3:0]),
        .div_i  (div_q),
        .char_o (char_cyc)
    );

    umc_timer tmr_i (
        .clk     (clk),
        .rst     (rst),
        .load_i  (tmr_load),
        .val_i   (tmr_val),
        .stop_i  (tmr_stop),
        .fire_o  (tmr_fire),
        .armed_o (tmr_armed)
    );

    // address decode
    assign dlab   = lcr_q[7];
    assign wr_dll = bus_wr && (bus_addr == A_DLL) && dlab;
    assign wr_dlm = bus_wr && (bus_addr == A_IER) && dlab;
    assign wr_ier = bus_wr && (bus_addr == A_IER) && !dlab;
    assign wr_lcr = bus_wr && (bus_addr == A_LCR);
    assign wr_mcr = bus_wr && (bus_addr == A_MCR);

    assign mcr_new     = mcr_t'({3'b000, bus_wdata[4:0]});
    assign mcr_kick    = wr_mcr && !mcr_new.loop && (mcr_new != mcr_q);
    assign rd_msr_live = bus_rd && (bus_addr == A_MSR) && !mcr_q.loop;
    assign sample      = tmr_fire || rd_msr_live || (wr_ier && bus_wdata[3]);
    assign msr_live    = msr_merge(msr_q, sync_lvl);

    // sampling timer control: one bus operation per cycle
    always_comb begin
        tmr_load = 1'b0;
        tmr_stop = 1'b0;
        tmr_val  = POLL_CYC;
        if (mcr_kick) begin
            tmr_load = 1'b1;
            tmr_val  = char_cyc;
        end else if (wr_ier) begin
            if (bus_wdata[3]) tmr_load = 1'b1;
            else              tmr_stop = 1'b1;
        end else if (rd_msr_live || tmr_fire) begin
            if (ier_q[3]) tmr_load = 1'b1;
            else          tmr_stop = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lcr_q <= 8'h00;
            ier_q <= 4'h0;
            div_q <= RST_DIV;
            mcr_q <= MCR_RST;
            msr_q <= MSR_RST;
            rts_q <= 1'b0;
            dtr_q <= 1'b0;
        end else begin
            if (wr_lcr) lcr_q <= bus_wdata;
            if (wr_ier) ier_q <= bus_wdata[3:0];
            if (wr_dll) div_q[7:0]  <= bus_wdata;
            if (wr_dlm) div_q[15:8] <= bus_wdata;
            if (wr_mcr) mcr_q <= mcr_new;
            if (mcr_kick) begin
                rts_q <= mcr_new.rts;
                dtr_q <= mcr_new.dtr;
            end
            if (rd_msr_live) begin
                msr_q <= '{lvl: msr_live.lvl, dlt: '0};
            end else if (sample) begin
                msr_q <= msr_live;
            end
        end
    end

    always_comb begin
        case (bus_addr)
            A_DLL:   bus_rdata = dlab ? div_q[7:0] : 8'h00;
            A_IER:   bus_rdata = dlab ? div_q[15:8] : {4'h0, ier_q};
            A_LCR:   bus_rdata = lcr_q;
            A_MCR:   bus_rdata = mcr_q;
            A_MSR:   bus_rdata = mcr_q.loop ? {2'b00, mcr_q.dtr, mcr_q.rts, 4'h0} : msr_live;
            default: bus_rdata = 8'h00;
        endcase
    end

    assign rts_o    = rts_q;
    assign dtr_o    = dtr_q;
    assign ms_irq_o = ier_q[3] && (|msr_q.dlt);

endmodule

// File: rtl/uart_modem_ctl_chk.sv
module uart_modem_ctl_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [2:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        rts_o,
    input logic        dtr_o,
    input logic [7:0]  msr_q,
    input logic [3:0]  sync_lvl,
    input logic        sample,
    input logic        rd_msr_live,
    input logic [15:0] div_q,
    input logic [31:0] char_cyc,
    input logic        mcr_kick,
    input logic        tmr_armed
);
    AST_LVL_TRACK: assert property (@(posedge clk) disable iff (rst)
        sample |=> (msr_q[7:4] == $past(sync_lvl)));  // R2

    AST_TERI_FALL_ONLY: assert property (@(posedge clk) disable iff (rst)
        (!$past(msr_q[2]) && msr_q[2]) |-> ($past(msr_q[6]) && !msr_q[6]));  // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        rd_msr_live |=> (msr_q[3:0] == 4'h0));  // R5

    AST_LOOP_LINES_HOLD: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 3'd4 && bus_wdata[4]) |=> ($stable(rts_o) && $stable(dtr_o)));  // R7

    AST_KICK_ARMS: assert property (@(posedge clk) disable iff (rst)
        mcr_kick |=> tmr_armed);  // R8

    AST_ZERO_DIV_HOLD: assert property (@(posedge clk) disable iff (rst)
        (div_q == 16'd0) |=> $stable(char_cyc));  // R10
endmodule

bind uart_modem_ctl uart_modem_ctl_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .rts_o       (rts_o),
    .dtr_o       (dtr_o),
    .msr_q       (msr_q),
    .sync_lvl    (sync_lvl),
    .sample      (sample),
    .rd_msr_live (rd_msr_live),
    .div_q       (div_q),
    .char_cyc    (char_cyc),
    .mcr_kick    (mcr_kick),
    .tmr_armed   (tmr_armed)
);

// File: tb/uart_modem_ctl_tb_top.sv
`timescale 1ns/1ps
module uart_modem_ctl_tb_top;
    localparam int CLK_HZ = 460_800;
    localparam int BASE   = 115_200;
    localparam int UNIT   = CLK_HZ / BASE;
    localparam int POLL   = CLK_HZ / 100;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = 3'd0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wd = 8'h00;
    logic [7:0] rdata;
    logic       cts = 1'b1, dsr = 1'b1, ri = 1'b0, dcd = 1'b1;
    logic       rts, dtr, irq;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    uart_modem_ctl #(.CLK_HZ(CLK_HZ), .BASE_BAUD(BASE), .POLL_HZ(100)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_wr(wr), .bus_rd(rd),
        .bus_wdata(wd), .bus_rdata(rdata), .cts_i(cts), .dsr_i(dsr),
        .ri_i(ri), .dcd_i(dcd), .rts_o(rts), .dtr_o(dtr), .ms_irq_o(irq)
    );

    // behavioural reference state
    logic [7:0]  m_msr, m_mcr, m_lcr;
    logic [3:0]  m_ier, m_s1, m_s2;
    logic [15:0] m_div;
    int          m_char, m_cnt;
    bit          m_armed, m_rts, m_dtr;
    bit          t_fire, t_dlab, t_wier, t_kick, t_rdl, t_smp;
    logic [7:0]  t_live;
    int          t_frm, t_nchar;

    function automatic logic [7:0] live_msr();
        logic [3:0] o, d;
        o = m_msr[7:4];
        d = m_msr[3:0] | (o ^ m_s2);
        d[2] = m_msr[2] | (o[2] & ~m_s2[2]);
        return {m_s2, d};
    endfunction

    function automatic logic [7:0] exp_rd(logic [2:0] a);
        case (a)
            3'd0: return m_lcr[7] ? m_div[7:0] : 8'h00;
            3'd1: return m_lcr[7] ? m_div[15:8] : {4'h0, m_ier};
            3'd3: return m_lcr;
            3'd4: return m_mcr;
            3'd6: return m_mcr[4] ? {2'b00, m_mcr[0], m_mcr[1], 4'h0} : live_msr();
            default: return 8'h00;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_msr = 8'hB0; m_mcr = 8'h08; m_lcr = 8'h00; m_ier = 4'h0;
            m_div = 16'd12; m_char = 12 * UNIT * 6; m_cnt = 0; m_armed = 1'b0;
            m_s1 = 4'h0; m_s2 = 4'h0; m_rts = 1'b0; m_dtr = 1'b0;
        end else begin
            t_fire = m_armed && (m_cnt == 1);
            t_dlab = m_lcr[7];
            t_wier = wr && addr == 3'd1 && !t_dlab;
            t_kick = wr && addr == 3'd4 && !wd[4] && ({3'b000, wd[4:0]} != m_mcr);
            t_rdl  = rd && addr == 3'd6 && !m_mcr[4];
            t_smp  = t_fire || t_rdl || (t_wier && wd[3]);
            t_live = live_msr();
            t_frm  = int'(m_lcr[1:0]) + 5 + (m_lcr[2] ? 2 : 1) + int'(m_lcr[3]);
            t_nchar = (m_div != 16'd0) ? int'(m_div) * UNIT * t_frm : m_char;
            if (t_kick) begin
                m_cnt = m_char; m_armed = 1'b1;
            end else if (t_wier) begin
                if (wd[3]) begin m_cnt = POLL; m_armed = 1'b1; end
                else m_armed = 1'b0;
            end else if (t_rdl || t_fire) begin
                if (m_ier[3]) begin m_cnt = POLL; m_armed = 1'b1; end
                else m_armed = 1'b0;
            end else if (m_armed) begin
                m_cnt = m_cnt - 1;
            end
            if (wr && addr == 3'd3) m_lcr = wd;
            if (t_wier) m_ier = wd[3:0];
            if (wr && addr == 3'd0 && t_dlab) m_div[7:0] = wd;
            if (wr && addr == 3'd1 && t_dlab) m_div[15:8] = wd;
            if (wr && addr == 3'd4) m_mcr = {3'b000, wd[4:0]};
            if (t_kick) begin m_rts = wd[1]; m_dtr = wd[0]; end
            if (t_rdl) m_msr = {t_live[7:4], 4'h0};
            else if (t_smp) m_msr = t_live;
            m_char = t_nchar;
            m_s2 = m_s1;
            m_s1 = {dcd, ri, dsr, cts};
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // per-clock comparison against the reference
    always @(negedge clk) begin
        if (!rst && !done) begin
            chk("R7 rts_o vs model", rts, m_rts);
            chk("R7 dtr_o vs model", dtr, m_dtr);
            chk("R12 ms_irq_o vs model", irq, m_ier[3] && (|m_msr[3:0]));
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        addr = a; wd = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        #1;
        d = rdata;
        chk("R5 R11 read vs model", d, exp_rd(a));
        @(posedge clk);
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic count_to_irq(output int n);
        n = 0;
        do begin
            @(posedge clk);
            @(negedge clk);
            n++;
        end while (!irq && n < 20000);
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        logic [7:0] v;
        int n;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        settle();

        // R1 reset state
        chk("R1 rts_o", rts, 0);
        chk("R1 dtr_o", dtr, 0);
        chk("R1 ms_irq_o", irq, 0);
        bus_read(3'd6, v); chk("R1 status", v, 8'hB0);
        bus_read(3'd4, v); chk("R1 control", v, 8'h08);
        bus_read(3'd1, v); chk("R1 int enable", v, 8'h00);
        bus_read(3'd3, v); chk("R1 line control", v, 8'h00);
        bus_write(3'd3, 8'h80);
        bus_read(3'd0, v); chk("R1 divisor low", v, 8'h0C);
        bus_read(3'd1, v); chk("R1 divisor high", v, 8'h00);
        bus_write(3'd3, 8'h00);

        // R2 R3 R5 change of clear-to-send, then clear on read
        cts = 1'b0; settle();
        bus_read(3'd6, v); chk("R2 R3 status after cts fall", v, 8'hA1);
        bus_read(3'd6, v); chk("R5 deltas cleared", v, 8'hA0);

        // R12 R3 periodic sample raises a sticky flag
        bus_write(3'd1, 8'h08);
        chk("R12 no flag without change", irq, 0);
        dcd = 1'b0;
        repeat (POLL + 100) @(negedge clk);
        chk("R12 flag after poll", irq, 1);
        repeat (100) @(negedge clk);
        chk("R3 flag sticky", irq, 1);
        bus_read(3'd6, v); chk("R3 carrier delta", v, 8'h28);
        chk("R12 flag cleared by read", irq, 0);

        // R4 ring edges
        ri = 1'b1; settle();
        bus_read(3'd6, v); chk("R4 ring rise no trailing flag", v, 8'h60);
        ri = 1'b0; settle();
        bus_read(3'd6, v); chk("R4 ring fall trailing flag", v, 8'h24);

        // R6 poll period measured from the read edge
        dsr = 1'b0;
        count_to_irq(n); chk("R6 poll period", n, POLL);
        bus_read(3'd6, v); chk("R6 polled value", v, 8'h02);
        bus_write(3'd1, 8'h00);
        ri = 1'b1;
        repeat (POLL + 400) @(negedge clk);
        ri = 1'b0; settle();
        bus_read(3'd6, v); chk("R6 no periodic sample when disabled", v, 8'h00);

        // R7 R11 control register and loopback
        bus_write(3'd4, 8'h03);
        chk("R7 rts driven", rts, 1);
        chk("R7 dtr driven", dtr, 1);
        bus_read(3'd4, v); chk("R7 control readback", v, 8'h03);
        bus_write(3'd4, 8'hF1);
        bus_read(3'd4, v); chk("R7 five bits kept", v, 8'h11);
        chk("R7 loopback keeps rts", rts, 1);
        chk("R7 loopback keeps dtr", dtr, 1);
        bus_read(3'd6, v); chk("R11 loopback status dtr", v, 8'h20);
        bus_write(3'd4, 8'h12);
        bus_read(3'd6, v); chk("R11 loopback status rts", v, 8'h10);
        bus_write(3'd4, 8'h00);
        chk("R7 rts released", rts, 0);
        chk("R7 dtr released", dtr, 0);

        // R8 one character time at reset settings
        bus_write(3'd1, 8'h08);
        bus_read(3'd6, v); chk("R8 clean start", v, 8'h00);
        cts = 1'b1; settle();
        bus_write(3'd4, 8'h02);
        count_to_irq(n); chk("R8 resample delay", n, 12 * UNIT * 6);

        // R9 eight data bits, two stop bits, parity, divisor 2
        bus_read(3'd6, v); chk("R9 clear", v, 8'h11);
        bus_write(3'd3, 8'h8F);
        bus_write(3'd0, 8'h02);
        bus_write(3'd1, 8'h00);
        bus_write(3'd3, 8'h0F);
        cts = 1'b0; settle();
        bus_write(3'd4, 8'h01);
        count_to_irq(n); chk("R9 computed character time", n, 2 * UNIT * 11);

        // R10 zero divisor keeps the last character time
        bus_read(3'd6, v); chk("R10 clear", v, 8'h01);
        bus_write(3'd3, 8'h8F);
        bus_write(3'd0, 8'h00);
        bus_write(3'd3, 8'h0C);
        cts = 1'b1; settle();
        bus_write(3'd4, 8'h02);
        count_to_irq(n); chk("R10 held character time", n, 2 * UNIT * 11);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule